// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the front end of a configuration space reached through two byte-wide I/O locations: an index location at 2Eh and a data location at 2Fh. Before any configuration access takes effect, software must write a fixed key byte, 87h, twice in a row to the index location. Writing the lock byte, AAh, to the index location closes the port again. While the port is locked, it answers every configuration access with nothing useful.

While the port is open, a write to the index location selects a register. Accesses to the data location then read or write that register. Index 07h is a logical-device register kept inside the block; its value picks which function's register bank is visible. For example, 08h selects the watchdog function. Every other index is passed to the back-end functions over a plain strobe interface. That interface carries the register index, the logical device number, the write data, a one-cycle write strobe and a one-cycle read strobe. The back end returns read data combinationally while the read strobe is high.

A host read on either decoded location returns its byte two clock edges after the request, flagged by a one-cycle valid pulse.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the latched index is 00h, the logical device number is 00h, and the strobes and read-valid output are low.
- R2: The port opens when the second of two consecutive index-location writes of 87h is taken. Data-location traffic between the two key writes does not break the sequence. While locked, a read of the index location returns FFh.
- R3: While locked, an index-location write of any byte other than 87h restarts the key sequence. So 87h, another byte, 87h leaves the port locked.
- R4: While open, an index-location write of AAh locks the port and leaves the latched index unchanged.
- R5: While locked, data-location writes produce no back-end write strobe and leave the logical device number unchanged. Data-location reads return FFh and raise no back-end read strobe. Index-location writes leave the latched index unchanged.
- R6: While open, an index-location write of any byte other than AAh latches that byte as the index, and a read of the index location returns it.
- R7: While open with index 07h, a data-location write stores the logical device number without a back-end strobe. A data-location read returns that number. Later back-end accesses carry it on the logical-device output.
- R8: While open with an index other than 07h, a data-location write raises the back-end write strobe for exactly one cycle, starting one edge after the request. During that cycle the index, logical device and write data outputs hold the values of the request.
- R9: While open with an index other than 07h, a data-location read raises the back-end read strobe one edge after the request. The host read data equals the back-end read data one edge later, with the read-valid pulse.
- R10: Accesses to any I/O address other than 2Eh and 2Fh produce no strobe, no read-valid pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the host access |
| io_wr | input | 1 | Host write request, one cycle |
| io_rd | input | 1 | Host read request, one cycle |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid with io_rvalid |
| io_rvalid | output | 1 | Host read data valid pulse |
| be_index | output | 8 | Register index presented to the back end |
| be_ldn | output | 8 | Logical device number presented to the back end |
| be_wdata | output | 8 | Write data presented to the back end |
| be_wr | output | 1 | Back-end write strobe |
| be_rd | output | 1 | Back-end read strobe |
| be_rdata | input | 8 | Back-end read data, combinational on the strobe outputs |

## Verification
The assertions assume that the host makes at most one request per cycle, so io_wr and io_rd are never high together. They also assume that the back end drives be_rdata in the cycle its read strobe is high. The bench issues every access as a single-cycle request followed by an idle cycle. It models the back end as a fixed arithmetic function of the index and logical device outputs, so read data is known without any look inside the block. The sweeps cover every index byte and every byte that could break the key sequence.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  typedef enum logic {
    RS_LOCAL = 1'b0,
    RS_BACK  = 1'b1
  } rd_src_e;
endpackage

// File: rtl/cfgp_port_decode.sv
module cfgp_port_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h002F
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  logic hit_idx, hit_dat;

  always_comb begin
    hit_idx = (io_addr == IDX_ADDR);
    hit_dat = (io_addr == DAT_ADDR);
    idx_wr  = hit_idx && io_wr;
    idx_rd  = hit_idx && io_rd;
    dat_wr  = hit_dat && io_wr;
    dat_rd  = hit_dat && io_rd;
  end
endmodule

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm import cfgp_pkg::*; #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_BYTE  = 8'h87,
  parameter logic [DATA_W-1:0] LOCK_BYTE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  lock_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_LOCKED;
    end else if (idx_wr) begin
      case (state_q)
        LK_LOCKED: state_q <= (wdata == KEY_BYTE) ? LK_ARMED : LK_LOCKED;
        LK_ARMED:  state_q <= (wdata == KEY_BYTE) ? LK_OPEN  : LK_LOCKED;
        LK_OPEN:   state_q <= (wdata == LOCK_BYTE) ? LK_LOCKED : LK_OPEN;
        default:   state_q <= LK_LOCKED;
      endcase
    end
  end

  assign unlocked = (state_q == LK_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(idx_wr && (wdata == KEY_BYTE))); // R2
  AST_LOCK_BYTE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (unlocked && idx_wr && (wdata == LOCK_BYTE)) |=> !unlocked); // R4
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'd3); // R3
endmodule

// File: rtl/cfgp_bank_regs.sv
module cfgp_bank_regs #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] LDN_INDEX = 8'h07,
  parameter logic [DATA_W-1:0] LOCK_BYTE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlocked,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] index_q,
  output logic [DATA_W-1:0] ldn_q,
  output logic              ldn_hit
);
  always_comb ldn_hit = (index_q == LDN_INDEX);

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (unlocked && idx_wr && (wdata != LOCK_BYTE)) index_q <= wdata;
      if (unlocked && dat_wr && ldn_hit)               ldn_q   <= wdata;
    end
  end

  AST_LDN_HOLD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(ldn_q)); // R5
  AST_INDEX_HOLD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(index_q)); // R5
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port import cfgp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 16'h002E,
  parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h002F,
  parameter logic [DATA_W-1:0] KEY_BYTE  = 8'h87,
  parameter logic [DATA_W-1:0] LOCK_BYTE = 8'hAA,
  parameter logic [DATA_W-1:0] LDN_INDEX = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic [DATA_W-1:0] be_index,
  output logic [DATA_W-1:0] be_ldn,
  output logic [DATA_W-1:0] be_wdata,
  output logic              be_wr,
  output logic              be_rd,
  input  logic [DATA_W-1:0] be_rdata
);
  logic idx_wr, idx_rd, dat_wr, dat_rd;
  logic unlocked, ldn_hit;
  logic [DATA_W-1:0] index_q, ldn_q;

  cfgp_port_decode #(.ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  cfgp_key_fsm #(.DATA_W(DATA_W), .KEY_BYTE(KEY_BYTE), .LOCK_BYTE(LOCK_BYTE)) u_fsm (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(io_wdata), .unlocked(unlocked)
  );

  cfgp_bank_regs #(.DATA_W(DATA_W), .LDN_INDEX(LDN_INDEX), .LOCK_BYTE(LOCK_BYTE)) u_regs (
    .clk(clk), .rst(rst), .unlocked(unlocked), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(io_wdata), .index_q(index_q), .ldn_q(ldn_q), .ldn_hit(ldn_hit)
  );

  logic be_acc, rd_any;
  always_comb begin
    be_acc = unlocked && (dat_wr || dat_rd) && !ldn_hit;
    rd_any = idx_rd || dat_rd;
  end

  // back-end strobe stage
  always_ff @(posedge clk) begin
    if (rst) begin
      be_wr    <= 1'b0;
      be_rd    <= 1'b0;
      be_index <= '0;
      be_ldn   <= '0;
      be_wdata <= '0;
    end else begin
      be_wr <= be_acc && dat_wr;
      be_rd <= be_acc && dat_rd;
      if (be_acc) begin
        be_index <= index_q;
        be_ldn   <= ldn_q;
        be_wdata <= io_wdata;
      end
    end
  end

  // two-stage host read pipeline
  rd_src_e           src_q;
  logic              rpend_q;
  logic [DATA_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= RS_LOCAL;
      rpend_q   <= 1'b0;
      snap_q    <= '0;
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      rpend_q <= rd_any;
      if (rd_any) begin
        if (!unlocked) begin
          src_q  <= RS_LOCAL;
          snap_q <= '1;
        end else if (idx_rd) begin
          src_q  <= RS_LOCAL;
          snap_q <= index_q;
        end else if (ldn_hit) begin
          src_q  <= RS_LOCAL;
          snap_q <= ldn_q;
        end else begin
          src_q  <= RS_BACK;
          snap_q <= '1;
        end
      end
      io_rvalid <= rpend_q;
      if (rpend_q) io_rdata <= (src_q == RS_BACK) ? be_rdata : snap_q;
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_rd)); // R9
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(be_wr && be_rd)); // R8
  AST_WR_ONLY_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    be_wr |-> $past(unlocked && io_wr)); // R5
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    be_wr |=> !be_wr); // R8
  AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    be_rd |-> $past(io_rd && (io_addr == DAT_ADDR))); // R9
  AST_RVALID_DECODED: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(rpend_q)); // R10
endmodule

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata, be_index, be_ldn, be_wdata, be_rdata;
  logic        io_rvalid, be_wr, be_rd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic       c_wr, c_rd, c_rv;
  logic [7:0] c_idx, c_ldn, c_wd, c_rdata;

  always #10 clk = ~clk;

  function automatic logic [7:0] be_model(input logic [7:0] idx, input logic [7:0] ldn);
    return idx ^ {ldn[3:0], ldn[7:4]} ^ 8'h5A;
  endfunction

  assign be_rdata = be_model(be_index, be_ldn);

  keyed_cfg_port dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .be_index(be_index), .be_ldn(be_ldn), .be_wdata(be_wdata),
    .be_wr(be_wr), .be_rd(be_rd), .be_rdata(be_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
    c_wr = be_wr; c_idx = be_index; c_ldn = be_ldn; c_wd = be_wdata; c_rv = io_rvalid;
  endtask

  task automatic io_read(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0;
    c_rd = be_rd; c_idx = be_index; c_ldn = be_ldn;
    @(posedge clk);
    @(negedge clk);
    c_rv = io_rvalid; c_rdata = io_rdata;
  endtask

  task automatic do_unlock();
    io_write(16'h2E, 8'h87);
    io_write(16'h2E, 8'h87);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset outputs
    chk("R1 be_wr", {7'd0, be_wr}, 8'h00);
    chk("R1 be_rd", {7'd0, be_rd}, 8'h00);
    chk("R1 rvalid", {7'd0, io_rvalid}, 8'h00);

    // R2: locked index read gives FF
    io_read(16'h2E);
    chk("R2 locked idx rvalid", {7'd0, c_rv}, 8'h01);
    chk("R2 locked idx data", c_rdata, 8'hFF);
    // R5: locked data read and write
    io_read(16'h2F);
    chk("R5 locked rd strobe", {7'd0, c_rd}, 8'h00);
    chk("R5 locked rd data", c_rdata, 8'hFF);
    io_write(16'h2F, 8'h33);
    chk("R5 locked wr strobe", {7'd0, c_wr}, 8'h00);
    io_write(16'h2E, 8'h07);
    io_write(16'h2F, 8'h99);
    chk("R5 locked ldn wr strobe", {7'd0, c_wr}, 8'h00);

    // R1: index and ldn at reset values once open
    do_unlock();
    io_read(16'h2E);
    chk("R1 index reset", c_rdata, 8'h00);
    io_write(16'h2E, 8'h07);
    io_read(16'h2F);
    chk("R1 ldn reset", c_rdata, 8'h00);

    // R6 R8 R9: sweep every index except ldn and lock bytes
    for (int i = 0; i < 256; i++) begin
      if (i == 8'h07 || i == 8'hAA) continue;
      io_write(16'h2E, 8'(i));
      io_read(16'h2E);
      chk("R6 index readback", c_rdata, 8'(i));
      io_write(16'h2F, 8'(i) ^ 8'hC3);
      chk("R8 wr strobe", {7'd0, c_wr}, 8'h01);
      chk("R8 wr index", c_idx, 8'(i));
      chk("R8 wr data", c_wd, 8'(i) ^ 8'hC3);
      chk("R8 wr ldn", c_ldn, 8'h00);
      @(negedge clk);
      chk("R8 wr one cycle", {7'd0, be_wr}, 8'h00);
      io_read(16'h2F);
      chk("R9 rd strobe", {7'd0, c_rd}, 8'h01);
      chk("R9 rvalid", {7'd0, c_rv}, 8'h01);
      chk("R9 rd data", c_rdata, be_model(8'(i), 8'h00));
    end

    // R7: logical device number
    for (int k = 0; k < 8; k++) begin
      logic [7:0] ld;
      ld = 8'(k * 37 + 1);
      io_write(16'h2E, 8'h07);
      io_write(16'h2F, ld);
      chk("R7 ldn no strobe", {7'd0, c_wr}, 8'h00);
      io_read(16'h2F);
      chk("R7 ldn no rd strobe", {7'd0, c_rd}, 8'h00);
      chk("R7 ldn readback", c_rdata, ld);
      io_write(16'h2E, 8'h30);
      io_write(16'h2F, 8'h5C);
      chk("R7 ldn on back end", c_ldn, ld);
      io_read(16'h2F);
      chk("R7 bank read", c_rdata, be_model(8'h30, ld));
    end
    io_write(16'h2E, 8'h07);
    io_write(16'h2F, 8'h08);

    // R10: other addresses
    io_write(16'h2E, 8'h44);
    io_write(16'h002D, 8'h12);
    chk("R10 wr other addr", {7'd0, c_wr}, 8'h00);
    io_write(16'h012E, 8'hAA);
    io_write(16'h0030, 8'h66);
    chk("R10 wr other addr2", {7'd0, c_wr}, 8'h00);
    io_read(16'h002D);
    chk("R10 rd no rvalid", {7'd0, c_rv}, 8'h00);
    chk("R10 rd no strobe", {7'd0, c_rd}, 8'h00);
    io_read(16'h2E);
    chk("R10 state unchanged", c_rdata, 8'h44);

    // R4: lock byte
    io_write(16'h2E, 8'hAA);
    io_read(16'h2E);
    chk("R4 locked after AA", c_rdata, 8'hFF);
    io_write(16'h2F, 8'h11);
    chk("R4 no wr after lock", {7'd0, c_wr}, 8'h00);
    io_write(16'h2E, 8'h55);
    io_write(16'h2E, 8'h07);
    io_write(16'h2F, 8'hEE);
    do_unlock();
    io_read(16'h2E);
    chk("R4 index kept over lock", c_rdata, 8'h44);
    chk("R5 index kept while locked", c_rdata, 8'h44);
    io_write(16'h2E, 8'h07);
    io_read(16'h2F);
    chk("R5 ldn kept while locked", c_rdata, 8'h08);
    io_write(16'h2E, 8'hAA);

    // R3: any other byte between keys restarts the sequence
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h87) continue;
      io_write(16'h2E, 8'h87);
      io_write(16'h2E, 8'(b));
      io_write(16'h2E, 8'h87);
      io_read(16'h2E);
      chk("R3 broken key stays locked", c_rdata, 8'hFF);
      io_write(16'h2E, 8'h00);
    end

    // R2: data traffic between keys does not break the sequence
    io_write(16'h2E, 8'h87);
    io_write(16'h2F, 8'h21);
    io_read(16'h2F);
    io_write(16'h2E, 8'h87);
    io_read(16'h2E);
    chk("R2 open despite data traffic", c_rdata, 8'h07);
    io_write(16'h2E, 8'hAA);
    io_write(16'h2E, 8'h87);
    io_read(16'h2E);
    chk("R2 single key stays locked", c_rdata, 8'hFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule